// File: doc/BRIEF.md
# Exception and Interrupt Entry Controller

This controller performs CPU entry into a trap handler. When the core strobes `start`, the controller looks at the pending exception code and the interrupt request. It decides whether an exception is taken, an interrupt is taken, or nothing happens. If entry happens, it saves the machine state and produces the new status register and program counter for the handler. An exception always wins over an interrupt. While the block bit of the status register is set, a non-maskable class of behaviour applies: almost every exception becomes a reset, and interrupts are ignored unless the core was woken from halt.

For interrupts the controller sends the current interrupt mask level to an external interrupt controller. In the same cycle it takes back a vector and a valid flag. Entry depends on the kind of event:

- Each exception code maps to one of three handler targets: the fixed reset address, the vector base plus 0x400, or the vector base plus 0x100.
- Interrupts go to the vector base plus 0x600.
- Entry from a branch delay slot moves the saved PC back by 2, so that the branch is executed again.
- The software-trap code moves the saved PC forward by 2.

The state machine has three states:

- ST_IDLE waits for `start`.
- ST_TAKE is the one-cycle done state after an entry.
- ST_SKIP is the one-cycle done state when nothing was taken.

The transitions are:

- ST_IDLE goes to ST_TAKE on start with an event to take.
- ST_IDLE goes to ST_SKIP on start without one.
- ST_TAKE and ST_SKIP always return to ST_IDLE.

Top module: `trap_entry_ctrl`

## Requirements
- R1: A pending exception (any `exc_code` other than 0xFFF) is taken ahead of an asserted `irq_req`. The interrupt is considered only when `exc_code` is 0xFFF, and an exception entry leaves `intevt` unchanged.
- R2: With status bit 28 (block) set, a pending exception whose code is not 0x1E0 is taken as code 0x000. Code 0x1E0 is taken unchanged.
- R3: With status bit 28 set, an interrupt is not taken unless `halt_wake` is high. `halt_wake_clr` pulses in the done cycle of any entry made while bit 28 was set.
- R4: While `start` is accepted with `irq_req` high and no exception pending, `ic_query` is high and `ic_level` equals status bits [7:4]. If `ic_vec_ok` is low, no entry is made.
- R5: On entry, `ssr` gets `sr_in`, `spc` gets `pc_in`, `sgr` gets `r15_in`, and `sr_out` is `sr_in` with bits 28, 29 and 30 set.
- R6: If any bit of `slot_flags` is set at entry, `spc` is `pc_in` minus 2 and `slot_clr` pulses in the done cycle.
- R7: Codes 0x000, 0x020 and 0x140 clear status bit 15, set bits [7:4] to 0xF and give `pc_out` = 0xA0000000.
- R8: Codes 0x040 and 0x060 give `pc_out` = `vbr_in` + 0x400.
- R9: Code 0x160 adds 2 to the saved PC. It and every other exception code give `pc_out` = `vbr_in` + 0x100.
- R10: An exception writes its effective code to `expevt`. An interrupt writes `ic_vec` to `intevt` and gives `pc_out` = `vbr_in` + 0x600.
- R11: After reset all outputs are zero. `start` seen in ST_IDLE raises `done` for exactly the next cycle. At most one of `taken_exc`/`taken_irq` is high, and `start` during the done cycle is ignored.
- R12: When no entry is made, `ssr`, `spc`, `sgr`, `sr_out`, `pc_out`, `expevt` and `intevt` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request to evaluate and perform entry |
| exc_code | input | 12 | Pending exception code, 0xFFF = none |
| irq_req | input | 1 | External interrupt request |
| halt_wake | input | 1 | Interrupt arrived while halted |
| ic_vec | input | 12 | Vector returned by interrupt controller |
| ic_vec_ok | input | 1 | Returned vector is valid |
| ic_query | output | 1 | Mask-level query to interrupt controller |
| ic_level | output | 4 | Current interrupt mask level |
| sr_in | input | 32 | Current status register |
| pc_in | input | 32 | Current PC |
| r15_in | input | 32 | Current general register 15 |
| vbr_in | input | 32 | Vector base register |
| slot_flags | input | 3 | Delay-slot flags of the current instruction |
| done | output | 1 | Decision complete (one cycle) |
| taken_exc | output | 1 | Exception entry made, pending exception consumed |
| taken_irq | output | 1 | Interrupt entry made |
| halt_wake_clr | output | 1 | Clear the halt-wake flag |
| slot_clr | output | 1 | Clear delay-slot flags |
| ssr | output | 32 | Saved status |
| spc | output | 32 | Saved PC |
| sgr | output | 32 | Saved R15 |
| expevt | output | 12 | Exception event code |
| intevt | output | 12 | Interrupt event code |
| sr_out | output | 32 | New status register |
| pc_out | output | 32 | Handler PC |

## Verification
The interrupt query is combinational, so `ic_query` and `ic_level` are checked in the same cycle as the accepted `start`, before the clock edge. Every other result goes through one register. The saved state, the new SR and PC, the event codes and the `done`, taken and clear pulses are all checked one cycle after `start`, at the falling edge of the done cycle. The start-held-twice case is checked for two cycles, to show that the second strobe does not load anything.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;
    localparam int CODE_W   = 12;
    localparam int SR_FD    = 15;
    localparam int SR_BL    = 28;
    localparam int SR_RB    = 29;
    localparam int SR_MD    = 30;
    localparam int SR_IM_LO = 4;
    localparam int IM_W     = 4;

    localparam logic [CODE_W-1:0] CODE_NONE     = '1;
    localparam logic [CODE_W-1:0] CODE_RESET    = 12'h000;
    localparam logic [CODE_W-1:0] CODE_MANUAL   = 12'h020;
    localparam logic [CODE_W-1:0] CODE_MULTIHIT = 12'h140;
    localparam logic [CODE_W-1:0] CODE_MISS_RD  = 12'h040;
    localparam logic [CODE_W-1:0] CODE_MISS_WR  = 12'h060;
    localparam logic [CODE_W-1:0] CODE_SWTRAP   = 12'h160;
    localparam logic [CODE_W-1:0] CODE_UNMASKED = 12'h1E0;

    localparam int OFS_GENERAL = 'h100;
    localparam int OFS_MISS    = 'h400;
    localparam int OFS_IRQ     = 'h600;
    localparam logic [31:0] RESET_PC = 32'hA000_0000;

    typedef enum logic [1:0] {ACT_NONE, ACT_EXC, ACT_IRQ} act_e;
    typedef enum logic [1:0] {ST_IDLE, ST_TAKE, ST_SKIP} st_e;
endpackage

// File: rtl/trap_arbiter.sv
module trap_arbiter
    import trap_entry_pkg::*;
(
    input  logic [CODE_W-1:0] exc_code,
    input  logic              irq_req,
    input  logic              halt_wake,
    input  logic              blocked,
    input  logic              ic_vec_ok,
    output act_e              act,
    output logic [CODE_W-1:0] eff_code,
    output logic              want_query,
    output logic              wake_clr
);
    logic exc_pend;

    assign exc_pend   = (exc_code != CODE_NONE);
    assign want_query = irq_req && !exc_pend;

    always_comb begin
        act      = ACT_NONE;
        eff_code = exc_code;
        wake_clr = 1'b0;
        if (exc_pend) begin
            act      = ACT_EXC;
            wake_clr = blocked;
            if (blocked && exc_code != CODE_UNMASKED) begin
                eff_code = CODE_RESET;
            end
        end else if (irq_req) begin
            if ((!blocked || halt_wake) && ic_vec_ok) begin
                act      = ACT_IRQ;
                wake_clr = blocked;
            end
        end
    end
endmodule

// File: rtl/trap_target.sv
module trap_target
    import trap_entry_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  act_e              act,
    input  logic [CODE_W-1:0] eff_code,
    input  logic [XLEN-1:0]   sr,
    input  logic [XLEN-1:0]   pc,
    input  logic [XLEN-1:0]   vbr,
    input  logic              in_slot,
    output logic [XLEN-1:0]   new_sr,
    output logic [XLEN-1:0]   new_pc,
    output logic [XLEN-1:0]   save_pc
);
    localparam logic [XLEN-1:0] INSN_BYTES = XLEN'(2);
    localparam logic [XLEN-1:0] ADD_GEN    = XLEN'(OFS_GENERAL);
    localparam logic [XLEN-1:0] ADD_MISS   = XLEN'(OFS_MISS);
    localparam logic [XLEN-1:0] ADD_IRQ    = XLEN'(OFS_IRQ);
    localparam logic [XLEN-1:0] RST_TGT    = XLEN'(RESET_PC);

    always_comb begin
        new_sr         = sr;
        new_sr[SR_BL]  = 1'b1;
        new_sr[SR_MD]  = 1'b1;
        new_sr[SR_RB]  = 1'b1;
        save_pc        = in_slot ? (pc - INSN_BYTES) : pc;
        new_pc         = vbr + ADD_GEN;
        if (act == ACT_IRQ) begin
            new_pc = vbr + ADD_IRQ;
        end else begin
            case (eff_code)
                CODE_RESET, CODE_MANUAL, CODE_MULTIHIT: begin
                    new_sr[SR_FD]              = 1'b0;
                    new_sr[SR_IM_LO +: IM_W]   = '1;
                    new_pc                     = RST_TGT;
                end
                CODE_MISS_RD, CODE_MISS_WR: new_pc = vbr + ADD_MISS;
                CODE_SWTRAP:                save_pc = save_pc + INSN_BYTES;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl
    import trap_entry_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int SLOT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [11:0]       exc_code,
    input  logic              irq_req,
    input  logic              halt_wake,
    input  logic [11:0]       ic_vec,
    input  logic              ic_vec_ok,
    output logic              ic_query,
    output logic [3:0]        ic_level,
    input  logic [XLEN-1:0]   sr_in,
    input  logic [XLEN-1:0]   pc_in,
    input  logic [XLEN-1:0]   r15_in,
    input  logic [XLEN-1:0]   vbr_in,
    input  logic [SLOT_W-1:0] slot_flags,
    output logic              done,
    output logic              taken_exc,
    output logic              taken_irq,
    output logic              halt_wake_clr,
    output logic              slot_clr,
    output logic [XLEN-1:0]   ssr,
    output logic [XLEN-1:0]   spc,
    output logic [XLEN-1:0]   sgr,
    output logic [11:0]       expevt,
    output logic [11:0]       intevt,
    output logic [XLEN-1:0]   sr_out,
    output logic [XLEN-1:0]   pc_out
);
    st_e               state, state_nx;
    act_e              act, kind_q;
    logic [CODE_W-1:0] eff_code;
    logic              want_query, wake_clr, accept, in_slot;
    logic [XLEN-1:0]   new_sr, new_pc, save_pc;

    assign accept  = (state == ST_IDLE) && start;
    assign in_slot = |slot_flags;

    trap_arbiter u_arb (
        .exc_code   (exc_code),
        .irq_req    (irq_req),
        .halt_wake  (halt_wake),
        .blocked    (sr_in[SR_BL]),
        .ic_vec_ok  (ic_vec_ok),
        .act        (act),
        .eff_code   (eff_code),
        .want_query (want_query),
        .wake_clr   (wake_clr)
    );

    trap_target #(.XLEN(XLEN)) u_tgt (
        .act      (act),
        .eff_code (eff_code),
        .sr       (sr_in),
        .pc       (pc_in),
        .vbr      (vbr_in),
        .in_slot  (in_slot),
        .new_sr   (new_sr),
        .new_pc   (new_pc),
        .save_pc  (save_pc)
    );

    assign ic_query = accept && want_query;
    assign ic_level = sr_in[SR_IM_LO +: IM_W];

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start) state_nx = (act != ACT_NONE) ? ST_TAKE : ST_SKIP;
            ST_TAKE: state_nx = ST_IDLE;
            ST_SKIP: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q        <= ACT_NONE;
            halt_wake_clr <= 1'b0;
            slot_clr      <= 1'b0;
            ssr           <= '0;
            spc           <= '0;
            sgr           <= '0;
            expevt        <= '0;
            intevt        <= '0;
            sr_out        <= '0;
            pc_out        <= '0;
        end else begin
            halt_wake_clr <= 1'b0;
            slot_clr      <= 1'b0;
            if (accept) begin
                kind_q <= act;
                if (act != ACT_NONE) begin
                    ssr           <= sr_in;
                    spc           <= save_pc;
                    sgr           <= r15_in;
                    sr_out        <= new_sr;
                    pc_out        <= new_pc;
                    slot_clr      <= in_slot;
                    halt_wake_clr <= wake_clr;
                    if (act == ACT_EXC) expevt <= eff_code;
                    else                intevt <= ic_vec;
                end
            end
        end
    end

    assign done      = (state != ST_IDLE);
    assign taken_exc = (state == ST_TAKE) && (kind_q == ACT_EXC);
    assign taken_irq = (state == ST_TAKE) && (kind_q == ACT_IRQ);

    assert_done_next_R11: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> done);
    assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_one_kind_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({taken_exc, taken_irq}));
    assert_exc_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && exc_code != CODE_NONE) |=> (taken_exc && !taken_irq));
    assert_block_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && exc_code != CODE_NONE && exc_code != CODE_UNMASKED && sr_in[SR_BL])
        |=> (expevt == CODE_RESET));
    assert_save_sr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (!(taken_exc || taken_irq) || ssr == $past(sr_in)));
    assert_skip_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !taken_exc && !taken_irq) |-> ($stable(pc_out) && $stable(spc)));
endmodule

// File: tb/trap_entry_ctrl_bench.sv
module trap_entry_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [11:0] exc_code = 12'hFFF;
    logic        irq_req = 1'b0, halt_wake = 1'b0, ic_vec_ok = 1'b0;
    logic [11:0] ic_vec = '0;
    logic        ic_query;
    logic [3:0]  ic_level;
    logic [31:0] sr_in = '0, pc_in = '0, r15_in = '0, vbr_in = 32'h8C00_0000;
    logic [2:0]  slot_flags = '0;
    logic        done, taken_exc, taken_irq, halt_wake_clr, slot_clr;
    logic [31:0] ssr, spc, sgr, sr_out, pc_out;
    logic [11:0] expevt, intevt;

    int   nvec = 0, nbad = 0;
    logic q_seen;
    logic [3:0] lvl_seen;

    always #4 clk = ~clk;

    trap_entry_ctrl u_trap_entry_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .exc_code(exc_code),
        .irq_req(irq_req), .halt_wake(halt_wake), .ic_vec(ic_vec),
        .ic_vec_ok(ic_vec_ok), .ic_query(ic_query), .ic_level(ic_level),
        .sr_in(sr_in), .pc_in(pc_in), .r15_in(r15_in), .vbr_in(vbr_in),
        .slot_flags(slot_flags), .done(done), .taken_exc(taken_exc),
        .taken_irq(taken_irq), .halt_wake_clr(halt_wake_clr), .slot_clr(slot_clr),
        .ssr(ssr), .spc(spc), .sgr(sgr), .expevt(expevt), .intevt(intevt),
        .sr_out(sr_out), .pc_out(pc_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic setup(input logic [31:0] sr, input logic [31:0] pc, input logic [11:0] code,
                         input logic irq, input logic wake, input logic [11:0] vec,
                         input logic ok, input logic [2:0] slot);
        sr_in = sr; pc_in = pc; r15_in = pc ^ 32'h55; exc_code = code;
        irq_req = irq; halt_wake = wake; ic_vec = vec; ic_vec_ok = ok; slot_flags = slot;
    endtask

    // Strobe start in an idle cycle; return at the falling edge of the done cycle.
    task automatic fire();
        @(negedge clk);
        start = 1'b1;
        #1;
        q_seen = ic_query;
        lvl_seen = ic_level;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic t_reset();
        chk("R11 done", {31'b0, done}, 0);
        chk("R11 pc_out", pc_out, 0);
        chk("R11 ssr", ssr, 0);
        chk("R11 expevt", {20'b0, expevt}, 0);
    endtask

    task automatic t_general();
        setup(32'h0000_80A0, 32'h1000, 12'h180, 1'b1, 1'b0, 12'h320, 1'b1, 3'b000);
        fire();
        chk("R1 no query", {31'b0, q_seen}, 0);
        chk("R1 taken_exc", {31'b0, taken_exc}, 1);
        chk("R1 taken_irq", {31'b0, taken_irq}, 0);
        chk("R1 intevt", {20'b0, intevt}, 0);
        chk("R11 done", {31'b0, done}, 1);
        chk("R5 ssr", ssr, 32'h0000_80A0);
        chk("R5 spc", spc, 32'h1000);
        chk("R5 sgr", sgr, 32'h1055);
        chk("R5 sr_out", sr_out, 32'h7000_80A0);
        chk("R9 pc_out", pc_out, 32'h8C00_0100);
        chk("R10 expevt", {20'b0, expevt}, 32'h180);
        chk("R6 no slot_clr", {31'b0, slot_clr}, 0);
    endtask

    task automatic t_miss();
        setup(32'h0, 32'h1100, 12'h040, 1'b0, 1'b0, 0, 1'b0, 3'b000);
        fire();
        chk("R8 pc 040", pc_out, 32'h8C00_0400);
        setup(32'h0, 32'h1100, 12'h060, 1'b0, 1'b0, 0, 1'b0, 3'b000);
        fire();
        chk("R8 pc 060", pc_out, 32'h8C00_0400);
        chk("R10 expevt 060", {20'b0, expevt}, 32'h060);
    endtask

    task automatic t_reset_class();
        setup(32'h0000_80A0, 32'h1200, 12'h140, 1'b0, 1'b0, 0, 1'b0, 3'b000);
        fire();
        chk("R7 sr 140", sr_out, 32'h7000_00F0);
        chk("R7 pc 140", pc_out, 32'hA000_0000);
        setup(32'h0000_8030, 32'h1200, 12'h020, 1'b0, 1'b0, 0, 1'b0, 3'b000);
        fire();
        chk("R7 sr 020", sr_out, 32'h7000_00F0);
        chk("R7 pc 020", pc_out, 32'hA000_0000);
    endtask

    task automatic t_trap();
        setup(32'h0, 32'h2000, 12'h160, 1'b0, 1'b0, 0, 1'b0, 3'b000);
        fire();
        chk("R9 trap spc", spc, 32'h2002);
        chk("R9 trap pc", pc_out, 32'h8C00_0100);
        setup(32'h0, 32'h2000, 12'h160, 1'b0, 1'b0, 0, 1'b0, 3'b001);
        fire();
        chk("R6 trap in slot spc", spc, 32'h2000);
        chk("R6 slot_clr", {31'b0, slot_clr}, 1);
    endtask

    task automatic t_slot();
        setup(32'h0, 32'h3000, 12'h1A0, 1'b0, 1'b0, 0, 1'b0, 3'b100);
        fire();
        chk("R6 rewind spc", spc, 32'h2FFE);
        chk("R6 slot_clr", {31'b0, slot_clr}, 1);
        chk("R9 default pc", pc_out, 32'h8C00_0100);
    endtask

    task automatic t_block();
        setup(32'h1000_80A0, 32'h3100, 12'h0E0, 1'b0, 1'b0, 0, 1'b0, 3'b000);
        fire();
        chk("R2 expevt", {20'b0, expevt}, 0);
        chk("R2 pc", pc_out, 32'hA000_0000);
        chk("R2 sr", sr_out, 32'h7000_00F0);
        chk("R3 wake_clr exc", {31'b0, halt_wake_clr}, 1);
        setup(32'h1000_00A0, 32'h3100, 12'h1E0, 1'b0, 1'b0, 0, 1'b0, 3'b000);
        fire();
        chk("R2 1E0 kept", {20'b0, expevt}, 32'h1E0);
        chk("R2 1E0 pc", pc_out, 32'h8C00_0100);
        chk("R2 1E0 sr", sr_out, 32'h7000_00A0);
    endtask

    task automatic t_irq();
        setup(32'h0000_00D0, 32'h4000, 12'hFFF, 1'b1, 1'b0, 12'h320, 1'b1, 3'b000);
        fire();
        chk("R4 query", {31'b0, q_seen}, 1);
        chk("R4 level", {28'b0, lvl_seen}, 32'hD);
        chk("R10 taken_irq", {31'b0, taken_irq}, 1);
        chk("R10 intevt", {20'b0, intevt}, 32'h320);
        chk("R10 irq pc", pc_out, 32'h8C00_0600);
        chk("R10 expevt kept", {20'b0, expevt}, 32'h1E0);
        chk("R5 irq sr", sr_out, 32'h7000_00D0);
        chk("R3 no wake_clr", {31'b0, halt_wake_clr}, 0);
    endtask

    task automatic t_irq_bad();
        setup(32'h0000_0090, 32'h4100, 12'hFFF, 1'b1, 1'b0, 12'h340, 1'b0, 3'b000);
        fire();
        chk("R4 level", {28'b0, lvl_seen}, 32'h9);
        chk("R4 done", {31'b0, done}, 1);
        chk("R4 not taken", {31'b0, taken_irq}, 0);
        chk("R12 intevt kept", {20'b0, intevt}, 32'h320);
        chk("R12 spc kept", spc, 32'h4000);
    endtask

    task automatic t_irq_block();
        setup(32'h1000_00D0, 32'h4200, 12'hFFF, 1'b1, 1'b0, 12'h360, 1'b1, 3'b000);
        fire();
        chk("R3 blocked", {31'b0, taken_irq}, 0);
        chk("R12 pc kept", pc_out, 32'h8C00_0600);
        chk("R12 ssr kept", ssr, 32'h0000_00D0);
        setup(32'h1000_00D0, 32'h4200, 12'hFFF, 1'b1, 1'b1, 12'h360, 1'b1, 3'b000);
        fire();
        chk("R3 woken", {31'b0, taken_irq}, 1);
        chk("R3 intevt", {20'b0, intevt}, 32'h360);
        chk("R3 wake_clr", {31'b0, halt_wake_clr}, 1);
        chk("R3 spc", spc, 32'h4200);
    endtask

    task automatic t_none();
        setup(32'h0, 32'h5000, 12'hFFF, 1'b0, 1'b0, 0, 1'b1, 3'b000);
        fire();
        chk("R11 done none", {31'b0, done}, 1);
        chk("R11 none taken", {30'b0, taken_exc, taken_irq}, 0);
        chk("R12 sgr kept", sgr, 32'h4255);
    endtask

    task automatic t_busy();
        setup(32'h0, 32'h6000, 12'h180, 1'b0, 1'b0, 0, 1'b0, 3'b000);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        pc_in = 32'h7000;
        chk("R11 done first", {31'b0, done}, 1);
        chk("R11 spc first", spc, 32'h6000);
        @(negedge clk);
        start = 1'b0;
        chk("R11 start ignored done", {31'b0, done}, 0);
        chk("R11 start ignored spc", spc, 32'h6000);
    endtask

    initial begin
        #(8 * 100000);
        nbad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_general();
        t_miss();
        t_reset_class();
        t_trap();
        t_slot();
        t_block();
        t_irq();
        t_irq_bad();
        t_irq_block();
        t_none();
        t_busy();
        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule